// File: doc/BRIEF.md
# Command-Decoded Register Access Slave (SPI Mode 0)

This block is an SPI Mode 0 target that holds a small bank of byte registers. Every chip-select frame opens with one command byte from the host. The command byte sets the direction, the starting register and how many data bytes the frame may move. The data bytes follow directly. A single access moves one byte. A sequential access moves bytes to or from consecutive registers, up to the last register of the bank. The SPI pins are brought into the system clock domain through short synchronizers, so the system clock must run several times faster than SCK.

While the command byte is shifted in, SO is not driven. During the data bytes of a valid read, SO drives the register contents, most significant bit first. The output changes after falling SCK edges, so the host can sample it on the rising edges. A frame can carry only one command. Any byte after the permitted count is treated as an excess byte, even if it looks like a command. Two sticky flags report problems in the current frame: `errOverrun` for excess bytes and `errReserved` for an undefined command. Both flags are cleared when chip select is asserted again.

Top module: `spiRegSlave`

## Requirements
- R1: After reset, SO is undriven (`spiSoOe` = 0, `spiSo` high-impedance), both error flags are 0, and every register reads as 0x00.
- R2: The first byte of each frame is the command, received MSB first on rising SCK. SO stays undriven for all eight command bits.
- R3: The command encoding is as follows. Bits [7:4] = 0100 selects write and 1000 selects read. Bit 3 = 1 selects a sequential transfer. Bits [2:0] give the starting register. Any other value in bits [7:4] is a reserved command.
- R4: A write data byte, received MSB first, is stored into its register only when the 8th bit of that byte has been sampled.
- R5: During the data bytes of a valid read, SO is driven and returns the addressed register MSB first, updated after falling SCK. For writes, SO stays undriven.
- R6: A single command permits exactly one data byte. A sequential command starting at register a permits 8 - a bytes, which go to registers a, a+1 and so on, up to register 7.
- R7: For bytes beyond the permitted count, writes are ignored and reads return 0x00. `errOverrun` is set when the 8th bit of the first such byte is sampled and stays set to the end of the frame. A second command byte inside a frame counts as such an excess byte.
- R8: A reserved command changes no register, leaves SO undriven for the rest of the frame and sets `errReserved` on its 8th bit. Excess bytes after it do not set `errOverrun`.
- R9: Negating chip select ends the frame at once. A partly received byte is discarded and causes no write, and the next frame begins with a command byte.
- R10: Both error flags are cleared when chip select is next asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | Serial clock, idle low |
| spiCsN | input | 1 | Chip select, active low |
| spiSi | input | 1 | Serial data from the host |
| spiSo | output | 1 | Serial data to the host, high-impedance when not driven |
| spiSoOe | output | 1 | High while `spiSo` is driven |
| errOverrun | output | 1 | Sticky flag: excess data bytes were seen in the current frame |
| errReserved | output | 1 | Sticky flag: the current frame's command is reserved |

## Verification
The hardest situation to reach is the boundary between the last permitted byte and the first excess byte. Near that boundary the pointer, the remaining count and the next shift-out load all change around a single rising edge. The stimulus reaches this boundary on purpose in two ways. It starts sequential transfers at the top register, and it sends a second command byte inside a frame. Random frames then pick lengths of up to two bytes beyond the permitted count, for every starting register. Truncated frames that release chip select in the middle of a byte are also sent, and each is followed by a read-back of the register it could have touched.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  parameter int ADDR_W = 3;
  parameter int BYTE_W = 8;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ, OP_RSVD} opKindT;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA} phaseT;

  typedef struct packed {
    opKindT              kind;
    logic                burst;
    logic [ADDR_W-1:0]   addr;
  } opDecT;

  // strobes from control to datapath
  typedef struct packed {
    logic                wrEn;
    logic [ADDR_W-1:0]   ptr;
    logic                readActive;
    logic                readZero;
  } strobeT;

  function automatic opDecT decodeOp(input logic [BYTE_W-1:0] op);
    opDecT d;
    d.addr  = op[ADDR_W-1:0];
    d.burst = op[3];
    case (op[7:4])
      4'b0100: d.kind = OP_WRITE;
      4'b1000: d.kind = OP_READ;
      default: d.kind = OP_RSVD;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic siIn,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic csStart,
  output logic siBit
);
  logic [STAGES-1:0] sckPipe;
  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] siPipe;
  logic sckPrev;
  logic csPrev;
  logic sckS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
      sckPrev <= 1'b0;
      csPrev  <= 1'b0;
    end else begin
      sckPipe <= {sckPipe[STAGES-2:0], sckIn};
      csPipe  <= {csPipe[STAGES-2:0], csNIn};
      siPipe  <= {siPipe[STAGES-2:0], siIn};
      sckPrev <= sckS;
      csPrev  <= csActive;
    end
  end

  assign sckS     = sckPipe[STAGES-1];
  assign csActive = ~csPipe[STAGES-1];
  assign csStart  = csActive & ~csPrev;
  assign sckRise  = sckS & ~sckPrev & csActive;
  assign sckFall  = ~sckS & sckPrev & csActive;
  assign siBit    = siPipe[STAGES-1];
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csActive,
  input  logic              siBit,
  input  strobeT            strb,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              soBit
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regBank;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftIn;
  logic [BYTE_W-1:0] shiftOut;

  assign byteDone = sckRise && (bitCnt == LAST_BIT);
  assign rxByte   = {shiftIn[BYTE_W-2:0], siBit};
  assign soBit    = shiftOut[BYTE_W-1];

  // receive shifter and bit position; dropping CS discards a partial byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (!csActive) begin
      bitCnt  <= '0;
    end else if (sckRise) begin
      shiftIn <= rxByte;
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // transmit shifter: new byte at a byte boundary, shift on other falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftOut <= '0;
    end else if (sckFall && strb.readActive) begin
      if (bitCnt == '0)
        shiftOut <= strb.readZero ? '0 : regBank[strb.ptr];
      else
        shiftOut <= {shiftOut[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regBank <= '0;
    else if (strb.wrEn) regBank[strb.ptr] <= rxByte;
  end

  AST_WRITE_FULL_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (sckRise && bitCnt == LAST_BIT)); // R4
  AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> csActive); // R9
endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              csStart,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  output strobeT            strb,
  output logic              soOe,
  output logic              errOverrun,
  output logic              errReserved
);
  phaseT             phase;
  opKindT            kind;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  remaining;
  opDecT             dec;

  assign dec = decodeOp(rxByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      kind        <= OP_NONE;
      ptr         <= '0;
      remaining   <= '0;
      errOverrun  <= 1'b0;
      errReserved <= 1'b0;
    end else if (!csActive) begin
      phase <= PH_IDLE;
      kind  <= OP_NONE;
    end else if (csStart) begin
      phase       <= PH_CMD;
      kind        <= OP_NONE;
      remaining   <= '0;
      errOverrun  <= 1'b0;
      errReserved <= 1'b0;
    end else if (byteDone) begin
      if (phase == PH_CMD) begin
        phase <= PH_DATA;
        kind  <= dec.kind;
        ptr   <= dec.addr;
        if (dec.kind == OP_RSVD) begin
          remaining   <= '0;
          errReserved <= 1'b1;
        end else if (dec.burst) begin
          remaining <= CNT_W'(NUM_REGS) - CNT_W'(dec.addr);
        end else begin
          remaining <= CNT_W'(1);
        end
      end else if (phase == PH_DATA) begin
        if (remaining != '0) begin
          remaining <= remaining - 1'b1;
          ptr       <= ptr + 1'b1;
        end else if (kind != OP_RSVD) begin
          errOverrun <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wrEn       = byteDone && (phase == PH_DATA) && (kind == OP_WRITE)
                      && (remaining != '0);
    strb.ptr        = ptr;
    strb.readActive = csActive && (phase == PH_DATA) && (kind == OP_READ);
    strb.readZero   = (remaining == '0);
  end

  assign soOe = strb.readActive;

  AST_SO_HIZ_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DATA) |-> !soOe); // R2
  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errReserved |-> !strb.wrEn); // R8
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (errOverrun && csActive && !csStart) |=> errOverrun); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= CNT_W'(NUM_REGS)); // R6
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    csStart |=> (!errOverrun && !errReserved)); // R10
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSck,
  input  logic spiCsN,
  input  logic spiSi,
  output logic spiSo,
  output logic spiSoOe,
  output logic errOverrun,
  output logic errReserved
);
  logic sckRise;
  logic sckFall;
  logic csActive;
  logic csStart;
  logic siBit;
  logic byteDone;
  logic [BYTE_W-1:0] rxByte;
  logic soBit;
  strobeT strb;

  spiPinSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiSi),
    .sckRise(sckRise), .sckFall(sckFall), .csActive(csActive),
    .csStart(csStart), .siBit(siBit)
  );

  spiRegCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .csStart(csStart),
    .byteDone(byteDone), .rxByte(rxByte), .strb(strb), .soOe(spiSoOe),
    .errOverrun(errOverrun), .errReserved(errReserved)
  );

  spiRegDatapath i_dp (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csActive(csActive), .siBit(siBit), .strb(strb), .byteDone(byteDone),
    .rxByte(rxByte), .soBit(soBit)
  );

  assign spiSo = spiSoOe ? soBit : 1'bz;
endmodule

// File: tb/test_spiRegSlave.sv
`timescale 1ns/1ps
module test_spiRegSlave;
  localparam int HALF = 5;
  localparam int MAXB = 12;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSck = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSi = 1'b0;
  wire  spiSo;
  logic spiSoOe;
  logic errOverrun;
  logic errReserved;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  bit [7:0] model [8];
  bit [7:0] txBuf [MAXB];
  bit [7:0] rxBuf [MAXB];
  bit oeAllBuf [MAXB];
  bit oeAnyBuf [MAXB];
  bit cmdOeAny;

  always #2.5 clk = ~clk;

  spiRegSlave i_spiRegSlave (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoOe(spiSoOe), .errOverrun(errOverrun),
    .errReserved(errReserved)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit opValid(input bit [7:0] op);
    return (op[7:4] == 4'b0100) || (op[7:4] == 4'b1000);
  endfunction

  function automatic int opCount(input bit [7:0] op);
    if (!opValid(op)) return 0;
    return op[3] ? 8 - int'(op[2:0]) : 1;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input bit [7:0] tx, input int nBits, output bit [7:0] rx,
                          output bit oeAll, output bit oeAny);
    rx = '0; oeAll = 1'b1; oeAny = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      spiSi = tx[7-i];
      waitClk(HALF);
      rx = {rx[6:0], (spiSo === 1'b1)};
      oeAll = oeAll & spiSoOe;
      oeAny = oeAny | spiSoOe;
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  // one frame: command, nData full bytes, then optionally a partial byte
  task automatic doFrame(input bit [7:0] op, input int nData, input int partBits,
                         input int cmdBits = 8);
    bit [7:0] rx; bit a; bit b;
    spiCsN = 1'b0;
    waitClk(6);
    check(!errOverrun && !errReserved, "R10", "flags after CS assert",
          {errOverrun, errReserved}, 0);
    xferBits(op, cmdBits, rx, a, b);
    cmdOeAny = b;
    for (int i = 0; i < nData; i++) begin
      xferBits(txBuf[i], 8, rx, a, b);
      rxBuf[i] = rx; oeAllBuf[i] = a; oeAnyBuf[i] = b;
    end
    if (partBits > 0) xferBits(txBuf[nData], partBits, rx, a, b);
    waitClk(6);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  // full-frame check against the model; updates the model for writes
  task automatic runChecked(input bit [7:0] op, input int nData, input string tag);
    int cnt; int a;
    cnt = opCount(op);
    a = int'(op[2:0]);
    doFrame(op, nData, 0);
    check(!cmdOeAny, "R2", {tag, " SO driven in command"}, cmdOeAny, 0);
    if (!opValid(op)) begin
      for (int i = 0; i < nData; i++)
        check(!oeAnyBuf[i], "R8", {tag, " SO driven after reserved"}, oeAnyBuf[i], 0);
    end else if (op[7]) begin
      for (int i = 0; i < nData; i++) begin
        bit [7:0] exp;
        exp = (i < cnt) ? model[a+i] : 8'h00;
        check(oeAllBuf[i], "R5", {tag, " SO not driven in read"}, oeAllBuf[i], 1);
        check(rxBuf[i] == exp, (i < cnt) ? "R6" : "R7", {tag, " read byte"},
              rxBuf[i], exp);
      end
    end else begin
      for (int i = 0; i < nData; i++) begin
        if (i < cnt) model[a+i] = txBuf[i];
        check(!oeAnyBuf[i], "R5", {tag, " SO driven in write"}, oeAnyBuf[i], 0);
      end
    end
    check(errOverrun == (opValid(op) && nData > cnt), "R7", {tag, " overrun flag"},
          errOverrun, (opValid(op) && nData > cnt));
    check(errReserved == !opValid(op), "R8", {tag, " reserved flag"},
          errReserved, !opValid(op));
  endtask

  task automatic readAll(input string tag);
    runChecked(8'h88, 8, tag);
  endtask

  initial begin
    void'($urandom(32'h1c3a_5e17));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);

    // R1: reset state
    check(spiSoOe == 1'b0, "R1", "SO enable after reset", spiSoOe, 0);
    check(spiSo === 1'bz, "R1", "SO not high-Z after reset", spiSo, 0);
    check(!errOverrun && !errReserved, "R1", "flags after reset",
          {errOverrun, errReserved}, 0);
    readAll("R1 reset contents");

    // R3 R4 R5: single write and read
    txBuf[0] = 8'hA5;
    runChecked(8'h42, 1, "R4 single write");
    runChecked(8'h82, 1, "R3 single read");

    // R6: two-byte sequential write, then sequential read across it
    txBuf[0] = 8'h11; txBuf[1] = 8'h22;
    runChecked(8'h4D, 2, "R6 burst write");
    runChecked(8'h8D, 3, "R6 burst read");

    // R7: single read with an extra byte
    runChecked(8'h82, 2, "R7 single read overrun");

    // R6 R7: sequential write from the top register runs past the end
    txBuf[0] = 8'h7E; txBuf[1] = 8'hC3;
    runChecked(8'h4F, 2, "R7 burst write at top");
    readAll("R7 after top write");

    // R7: second command byte in the same frame is an excess byte
    txBuf[0] = 8'h5A; txBuf[1] = 8'h43; txBuf[2] = 8'h77;
    runChecked(8'h41, 3, "R7 chained command");
    runChecked(8'h8B, 5, "R7 chain read-back");

    // R8: reserved commands
    txBuf[0] = 8'hFF; txBuf[1] = 8'h00;
    runChecked(8'hC3, 2, "R8 reserved C3");
    runChecked(8'h50, 1, "R8 reserved 50");
    readAll("R8 contents unchanged");

    // R9: abort in the middle of a data byte
    txBuf[0] = 8'hFF;
    doFrame(8'h44, 0, 5);
    check(!errOverrun && !errReserved, "R9", "flags after abort",
          {errOverrun, errReserved}, 0);
    runChecked(8'h84, 1, "R9 partial byte not written");
    // R9: abort inside the command byte, next frame is a normal command
    doFrame(8'h48, 0, 0, 4);
    txBuf[0] = 8'h3C;
    runChecked(8'h46, 1, "R9 write after command abort");
    runChecked(8'h86, 1, "R9 read after command abort");

    // R10: overrun frame followed by a clean frame
    runChecked(8'h80, 2, "R10 overrun frame");
    runChecked(8'h80, 1, "R10 clean frame");

    // random frames
    for (int n = 0; n < 140; n++) begin
      bit [7:0] op; int r; int cnt; int nd;
      r = int'($urandom % 10);
      if (r < 4)      op = {4'b0100, 1'($urandom), 3'($urandom)};
      else if (r < 8) op = {4'b1000, 1'($urandom), 3'($urandom)};
      else begin
        op = 8'($urandom);
        if (opValid(op)) op[7:4] = 4'b1100;
      end
      cnt = opValid(op) ? opCount(op) : 1;
      nd = 1 + int'($urandom % (cnt + 2));
      if (nd > MAXB - 1) nd = MAXB - 1;
      for (int i = 0; i < MAXB; i++) txBuf[i] = 8'($urandom);
      runChecked(op, nd, "random");
    end
    readAll("final contents");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule